// File: doc/BRIEF.md
# DMA Transfer Count and Termination Controller

This block decides how long a peripheral DMA transfer runs and why it stopped. A host register port writes a 32-bit word count one byte at a time, selects whether counting is in force, and issues command opcodes. While a transfer is running, the block counts the word strobes that the data path reports. It ends the transfer when the count runs out, when an external end-of-transfer pin is asserted, when an internal short-packet event arrives, or when a DMA reset command is issued.

Each way a transfer can end, other than the reset, sets its own sticky cause bit. Software clears a cause bit by writing 1 to it, and each cause bit has an enable bit that lets it drive the interrupt output. Slave opcodes either count words or run until an end-of-transfer event, depending on the count-disable bit. Master opcodes always count and ignore the external end-of-transfer pin. The remaining count is visible at a port, so software and the bench can see how far a transfer got.

Top module: `dma_term_ctrl`

## Requirements
- R1: Writes to addresses 34h, 35h and 36h only stage bits [7:0], [15:8] and [23:16] of the count, and `remaining` does not change. A write to 37h loads `remaining` with that byte as bits [31:24] together with the three staged bytes.
- R2: Command opcodes 00h, 01h, 04h and 05h, written to address 31h while bit 0 of the configuration register at 30h is 0, start a counted slave transfer with `busy` high. Each `word_stb` decrements `remaining`. The strobe that brings it to zero ends the transfer and sets cause bit 0 (count done).
- R3: A `word_stb` while `busy` is low has no effect on `remaining`, `busy` or `cause`.
- R4: A counted command issued while `remaining` is 0 does not raise `busy`, and it sets cause bit 0 in the same cycle.
- R5: In a counted slave transfer, `ext_eot` ends the transfer in the cycle it is sampled and sets cause bit 1. If it coincides with the final decrement, cause bits 0 and 1 are both set.
- R6: With bit 0 of 30h at 1, a slave opcode starts an end-of-transfer-only transfer. Strobes do not decrement `remaining`, and the transfer ends only on `ext_eot`, `short_pkt` or a DMA reset.
- R7: Opcodes 06h and 07h start a master transfer that always counts, whatever the count-disable bit says. `ext_eot` has no effect on it.
- R8: `short_pkt` during any active transfer ends it and sets cause bit 2.
- R9: Opcode 0Fh written to 31h clears `busy` and sets no cause bit, even if an end event arrives in the same cycle.
- R10: Writing to address 32h clears each cause bit whose data bit is 1. A cause bit that is set in the same cycle stays 1.
- R11: `irq` is the OR of `cause` ANDed with the enable bits [2:0] of the register at 33h. The enable bits reset to 0.
- R12: After reset `busy`, `remaining`, `cause` and `irq` are 0. Any other opcode written to 31h leaves `busy` and `remaining` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 8 | Register write data |
| word_stb | input | 1 | One data word transferred this cycle |
| ext_eot | input | 1 | External end-of-transfer |
| short_pkt | input | 1 | Internal end-of-transfer (short packet) |
| busy | output | 1 | Transfer active |
| remaining | output | 32 | Working word count |
| cause | output | 3 | Sticky termination causes: bit 0 count done, bit 1 external, bit 2 internal |
| irq | output | 1 | Interrupt request |

## Verification
Two end conditions can fall in the same cycle: an external end-of-transfer and the strobe that consumes the last counted word. A sweep over counts 1 to 5 asserts `ext_eot` together with each strobe position in turn, including the last one. The expected remaining count and cause pattern are computed arithmetically: cause bit 1 alone for an early stop, bits 0 and 1 together when the stop lands on the last word. The same sweep run in master mode must show only bit 0. Reset-versus-event and clear-versus-set collisions are also driven in a single cycle.

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          word_stb,
  input  logic          ext_eot,
  input  logic          short_pkt,
  output logic          busy,
  output logic [CW-1:0] remaining,
  output logic [2:0]    cause,
  output logic          irq
);
  localparam logic [7:0] A_CFG = 8'h30, A_CMD = 8'h31, A_CLR = 8'h32, A_EN = 8'h33;
  localparam logic [7:0] A_CNT0 = 8'h34, A_CNT3 = 8'h37;
  localparam int SW = CW - 8;

  logic [SW-1:0] stage;
  logic          cnt_dis, mode_cnt, mode_master;
  logic [2:0]    irq_en;

  wire sel_cmd   = wr_en && wr_addr == A_CMD;
  wire op_slave  = wr_data == 8'h00 || wr_data == 8'h01 || wr_data == 8'h04 || wr_data == 8'h05;
  wire op_master = wr_data == 8'h06 || wr_data == 8'h07;
  wire start     = sel_cmd && (op_slave || op_master);
  wire abort     = sel_cmd && wr_data == 8'h0F;
  wire run       = busy && !start && !abort;
  wire dec       = run && mode_cnt && word_stb;
  wire hit0      = dec && remaining == CW'(1);
  wire xeot      = run && !mode_master && ext_eot;
  wire ieot      = run && short_pkt;
  wire zstart    = start && (op_master || !cnt_dis) && remaining == '0;
  wire [2:0] clr = (wr_en && wr_addr == A_CLR) ? wr_data[2:0] : 3'b000;
  wire [2:0] set = {ieot, xeot, hit0 | zstart};

  assign irq = |(cause & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage       <= '0;
      remaining   <= '0;
      cnt_dis     <= 1'b0;
      irq_en      <= 3'b000;
      busy        <= 1'b0;
      mode_cnt    <= 1'b0;
      mode_master <= 1'b0;
      cause       <= 3'b000;
    end else begin
      if (dec) remaining <= remaining - CW'(1);
      if (wr_en) begin
        if (wr_addr >= A_CNT0 && wr_addr < A_CNT3)
          stage[8*(wr_addr - A_CNT0) +: 8] <= wr_data;
        if (wr_addr == A_CNT3) remaining <= {wr_data, stage};
        if (wr_addr == A_CFG)  cnt_dis <= wr_data[0];
        if (wr_addr == A_EN)   irq_en  <= wr_data[2:0];
      end
      if (start) begin
        busy        <= !zstart;
        mode_cnt    <= op_master || !cnt_dis;
        mode_master <= op_master;
      end else if (abort || hit0 || xeot || ieot) begin
        busy <= 1'b0;
      end
      cause <= (cause & ~clr) | set;
    end
  end
endmodule

module dma_term_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [7:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic        word_stb,
  input logic        ext_eot,
  input logic        short_pkt,
  input logic        busy,
  input logic [31:0] remaining,
  input logic [2:0]  cause,
  input logic        irq,
  input logic        mode_cnt,
  input logic        mode_master
);
  a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cause == 3'b000 |-> !irq);
  a_r3_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !wr_en |=> $stable(remaining));
  a_r2_last_word: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mode_cnt && word_stb && remaining == 32'd1 && !wr_en |=> !busy && cause[0]);
  a_r5_ext_eot: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mode_master && ext_eot && !wr_en |=> !busy && cause[1]);
  a_r7_master_ext: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mode_master && ext_eot && !word_stb && !short_pkt && !wr_en |=> busy);
  a_r8_short: assert property (@(posedge clk) disable iff (!rst_n)
    busy && short_pkt && !wr_en |=> !busy && cause[2]);
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 8'h31 && wr_data == 8'h0F |=> !busy);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cause[0] && !(wr_en && wr_addr == 8'h32 && wr_data[0]) |=> cause[0]);
endmodule

bind dma_term_ctrl dma_term_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .word_stb(word_stb), .ext_eot(ext_eot), .short_pkt(short_pkt), .busy(busy),
  .remaining(remaining), .cause(cause), .irq(irq), .mode_cnt(mode_cnt),
  .mode_master(mode_master)
);

// File: tb/tb_dma_term_ctrl.sv
module tb_dma_term_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, word_stb = 1'b0, ext_eot = 1'b0, short_pkt = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic busy, irq;
  logic [31:0] remaining;
  logic [2:0] cause;
  int n_chk = 0, n_fail = 0;

  dma_term_ctrl dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic stb(input logic e, input logic s);
    word_stb = 1'b1; ext_eot = e; short_pkt = s;
    tick();
    word_stb = 1'b0; ext_eot = 1'b0; short_pkt = 1'b0;
  endtask

  task automatic load(input logic [31:0] v);
    wr(8'h34, v[7:0]); wr(8'h35, v[15:8]); wr(8'h36, v[23:16]); wr(8'h37, v[31:24]);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    #9 rst_n = 1'b1;
    tick();
    // R12 reset state
    chk("R12 busy", busy, 0); chk("R12 remaining", remaining, 0);
    chk("R12 cause", cause, 0); chk("R12 irq", irq, 0);

    // R1 staged bytes
    wr(8'h34, 8'h11); wr(8'h35, 8'h22); wr(8'h36, 8'h33);
    chk("R1 staged only", remaining, 0);
    wr(8'h37, 8'h44);
    chk("R1 commit", remaining, 32'h44332211);

    // R12 unknown opcode while idle
    wr(8'h31, 8'h02);
    chk("R12 unknown idle", busy, 0);

    // R2 R5 R7 sweep: slave (00h) and master (06h), eot at word k
    for (int m = 0; m < 2; m++) begin
      for (int n = 1; n <= 5; n++) begin
        for (int k = 0; k <= n; k++) begin
          int last;
          logic [2:0] ec;
          wr(8'h32, 8'h07);
          wr(8'h30, 8'h00);
          load(n);
          wr(8'h31, m == 0 ? 8'h00 : 8'h06);
          chk(m == 0 ? "R2 start" : "R7 start", busy, 1);
          last = (m == 0 && k > 0) ? k : n;
          for (int j = 1; j <= last; j++) stb(j == k, 1'b0);
          ec = (m == 1) ? 3'b001 : {1'b0, k > 0, last == n};
          chk(m == 0 ? "R5 busy" : "R7 busy", busy, 0);
          chk(m == 0 ? "R5 remaining" : "R7 remaining", remaining, n - last);
          chk(m == 0 ? "R5 cause" : "R7 cause", cause, ec);
          stb(1'b0, 1'b0);
          chk("R3 idle strobe", remaining, n - last);
        end
      end
    end

    // R3 idle strobes leave cause and busy
    wr(8'h32, 8'h07);
    stb(1'b0, 1'b0);
    chk("R3 cause", cause, 0); chk("R3 busy", busy, 0);

    // R4 zero count
    load(0);
    wr(8'h31, 8'h01);
    chk("R4 busy", busy, 0); chk("R4 cause", cause, 1);

    // R7 master ignores count disable
    wr(8'h32, 8'h07); wr(8'h30, 8'h01); load(2);
    wr(8'h31, 8'h07);
    stb(1'b0, 1'b0); stb(1'b0, 1'b0);
    chk("R7 dis ignored busy", busy, 0); chk("R7 dis ignored cause", cause, 1);

    // R6 eot-only: strobes do not count, short packet ends
    wr(8'h32, 8'h07); load(3);
    wr(8'h31, 8'h01);
    for (int i = 0; i < 5; i++) stb(1'b0, 1'b0);
    chk("R6 still busy", busy, 1); chk("R6 no decrement", remaining, 3);
    stb(1'b0, 1'b1);
    chk("R8 short busy", busy, 0); chk("R8 short cause", cause, 3'b100);
    wr(8'h32, 8'h07);
    wr(8'h31, 8'h04);
    stb(1'b1, 1'b0);
    chk("R6 ext busy", busy, 0); chk("R6 ext cause", cause, 3'b010);

    // R12 unknown opcode while busy
    wr(8'h32, 8'h07);
    wr(8'h31, 8'h00);
    wr(8'h31, 8'h09);
    chk("R12 unknown busy", busy, 1); chk("R12 unknown remaining", remaining, 3);

    // R9 reset with coincident eot
    ext_eot = 1'b1; short_pkt = 1'b1;
    wr(8'h31, 8'h0F);
    ext_eot = 1'b0; short_pkt = 1'b0;
    chk("R9 busy", busy, 0); chk("R9 cause", cause, 0);

    // R10 set wins over clear in same cycle
    wr(8'h30, 8'h00); load(1);
    wr(8'h31, 8'h05);
    wr_en = 1'b1; wr_addr = 8'h32; wr_data = 8'h01; word_stb = 1'b1;
    tick();
    wr_en = 1'b0; word_stb = 1'b0;
    chk("R10 set wins", cause, 1);

    // R11 enable mask, then R10 clear
    chk("R11 masked", irq, 0);
    wr(8'h33, 8'h01);
    chk("R11 enabled", irq, 1);
    wr(8'h33, 8'h06);
    chk("R11 other bits", irq, 0);
    wr(8'h32, 8'h01);
    chk("R10 cleared", cause, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule